// File: doc/BRIEF.md
# Branch Resolution and Next-Fetch-Address Unit

This unit sits beside the decode stage of a 32-bit RISC core whose instruction set exposes one branch delay slot. Each cycle, decode may present one control-transfer instruction together with its own address, its immediate field and the two source register values. The unit decides whether the transfer is taken. It then picks the next fetch address from one of four sources: the next sequential word, a target relative to the branch, an absolute target inside the current 256 MB region, or a target read from a register.

The instruction that follows a branch or jump always executes. For that reason a taken redirect is held for exactly one cycle. The fetch of the delay-slot word completes first, and only then is the target fetched. Instructions that make a call return the address just past the delay slot, so that the callee comes back to the instruction after it. The return address goes to the fixed link register.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `fetch_pc` equals the reset address (default 0x0040_0000), and `taken` and `link_we` are 0.
- R2: When no redirect is pending, `fetch_pc` advances by 4 on every clock edge.
- R3: Op code 1 (branch if equal) is taken when `rs_val == rt_val`. Op code 2 (branch if not equal) is taken when the two values differ.
- R4: The compares against zero treat `rs_val` as a signed number and ignore `rt_val`. Op 3 is taken when rs <= 0, op 4 when rs > 0, op 5 when rs < 0 and op 6 when rs >= 0.
- R5: A conditional branch targets `ins_pc + 4 + (sign-extended ins_imm[15:0] * 4)`.
- R6: Op 9 (jump) and op 10 (jump and link) target `{(ins_pc+4)[31:28], ins_imm[25:0], 2'b00}` and are always taken.
- R7: Op 11 (jump to register) is always taken and targets `rs_val`.
- R8: After the clock edge that accepts a taken transfer, `fetch_pc` is the previous value plus 4, which is the delay slot. After the next edge it is the target.
- R9: `link_we` is 1 for op 10 always. It is 1 for op 7 (branch and link if rs < 0) and op 8 (branch and link if rs >= 0) only when their condition holds. Whenever `link_we` is 1, `link_reg` is 31 and `link_addr` is `ins_pc + 8`. For every other case `link_we` is 0.
- R10: A control transfer presented in the cycle after an accepted redirect, which is the delay-slot cycle, is ignored. It gives `taken` = 0 and `link_we` = 0, and fetch still goes to the first target.
- R11: With `ins_valid` low, or with an op code outside 1..11 (0 means no transfer), `taken` and `link_we` are 0 and fetch continues sequentially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Decode holds an instruction this cycle |
| ins_op | input | 4 | Control-transfer op code (see requirements) |
| ins_pc | input | 32 | Address of the instruction in decode |
| ins_imm | input | 26 | Jump index; the low 16 bits are the branch offset |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| fetch_pc | output | 32 | Address to fetch in the current cycle |
| taken | output | 1 | The presented transfer redirects fetch |
| link_we | output | 1 | Write the return address to the link register |
| link_reg | output | 5 | Link register index |
| link_addr | output | 32 | Return address |

## Verification
The embedded properties check the delay-slot protocol on every cycle. A pending redirect lasts exactly one cycle. The fetch address steps by one word right after a redirect is accepted. No second redirect starts while one is pending. A link write never happens without a taken transfer, and an idle decode never redirects. Only the bench's vectors can show that each compare decides correctly at its signed edges (zero, the most negative value, minus one) and that the three target computations give the right addresses, including offset wrap-around and the region bits of an absolute jump.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_BEQ    = 4'd1,
    OP_BNE    = 4'd2,
    OP_BLEZ   = 4'd3,
    OP_BGTZ   = 4'd4,
    OP_BLTZ   = 4'd5,
    OP_BGEZ   = 4'd6,
    OP_BLTZAL = 4'd7,
    OP_BGEZAL = 4'd8,
    OP_J      = 4'd9,
    OP_JAL    = 4'd10,
    OP_JR     = 4'd11
  } ctl_op_e;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_REL = 2'd1,
    SRC_ABS = 2'd2,
    SRC_REG = 2'd3
  } tgt_src_e;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ctl_op_e          op,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output logic             cond_true,
  output logic             is_ctrl,
  output logic             is_link,
  output tgt_src_e         src
);

  logic rs_eq_rt;
  logic rs_neg;
  logic rs_zero;

  assign rs_eq_rt = (rs_val == rt_val);
  assign rs_neg   = rs_val[XLEN-1];
  assign rs_zero  = (rs_val == '0);

  always_comb begin
    cond_true = 1'b0;
    is_ctrl   = 1'b1;
    is_link   = 1'b0;
    src       = SRC_REL;
    case (op)
      OP_BEQ:    cond_true = rs_eq_rt;
      OP_BNE:    cond_true = ~rs_eq_rt;
      OP_BLEZ:   cond_true = rs_neg | rs_zero;
      OP_BGTZ:   cond_true = ~rs_neg & ~rs_zero;
      OP_BLTZ:   cond_true = rs_neg;
      OP_BGEZ:   cond_true = ~rs_neg;
      OP_BLTZAL: begin
        cond_true = rs_neg;
        is_link   = 1'b1;
      end
      OP_BGEZAL: begin
        cond_true = ~rs_neg;
        is_link   = 1'b1;
      end
      OP_J: begin
        cond_true = 1'b1;
        src       = SRC_ABS;
      end
      OP_JAL: begin
        cond_true = 1'b1;
        is_link   = 1'b1;
        src       = SRC_ABS;
      end
      OP_JR: begin
        cond_true = 1'b1;
        src       = SRC_REG;
      end
      default: begin
        is_ctrl = 1'b0;
        src     = SRC_SEQ;
      end
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16
) (
  input  tgt_src_e          src,
  input  logic [XLEN-1:0]   ins_pc,
  input  logic [XLEN-7:0]   ins_imm,
  input  logic [XLEN-1:0]   rs_val,
  output logic [XLEN-1:0]   tgt,
  output logic [XLEN-1:0]   link_addr
);

  localparam int IDX_W  = XLEN - 6;
  localparam int REGION = 4;
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  function automatic logic [XLEN-1:0] rel_target(
    input logic [XLEN-1:0]  pc,
    input logic [OFF_W-1:0] off
  );
    logic [XLEN-1:0] sext;
    sext = {{(XLEN-OFF_W){off[OFF_W-1]}}, off};
    return pc + WORD + (sext << 2);
  endfunction

  function automatic logic [XLEN-1:0] abs_target(
    input logic [XLEN-1:0]  pc,
    input logic [IDX_W-1:0] idx
  );
    logic [XLEN-1:0] pc_next;
    pc_next = pc + WORD;
    return {pc_next[XLEN-1:XLEN-REGION], idx, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] link_value(input logic [XLEN-1:0] pc);
    return pc + (WORD << 1);
  endfunction

  always_comb begin
    case (src)
      SRC_REL: tgt = rel_target(ins_pc, ins_imm[OFF_W-1:0]);
      SRC_ABS: tgt = abs_target(ins_pc, ins_imm);
      SRC_REG: tgt = rs_val;
      default: tgt = ins_pc + WORD;
    endcase
  end

  assign link_addr = link_value(ins_pc);

endmodule

// File: rtl/npc_seq.sv
module npc_seq #(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             redirect,
  input  logic [XLEN-1:0]  redir_tgt,
  output logic [XLEN-1:0]  fetch_pc,
  output logic             pend_valid
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pend_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_pc   <= RESET_PC;
      pend_valid <= 1'b0;
      pend_tgt   <= '0;
    end else begin
      fetch_pc   <= pend_valid ? pend_tgt : fetch_pc + STEP;
      pend_valid <= redirect;
      if (redirect) pend_tgt <= redir_tgt;
    end
  end

  // A redirect is pending for one cycle only
  assert_pend_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |=> !pend_valid);

  // The delay-slot word is fetched first
  assert_delay_slot_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (fetch_pc == $past(fetch_pc) + STEP));

  // No new redirect starts inside the delay-slot cycle
  assert_no_redirect_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> !redirect);

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              OFF_W    = 16,
  parameter int              REG_W    = 5,
  parameter int              LINK_REG = 31,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [3:0]       ins_op,
  input  logic [XLEN-1:0]  ins_pc,
  input  logic [XLEN-7:0]  ins_imm,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output logic [XLEN-1:0]  fetch_pc,
  output logic             taken,
  output logic             link_we,
  output logic [REG_W-1:0] link_reg,
  output logic [XLEN-1:0]  link_addr
);

  ctl_op_e         op;
  tgt_src_e        src;
  logic            cond_true;
  logic            is_ctrl;
  logic            is_link;
  logic            pend_valid;
  logic            accept;
  logic [XLEN-1:0] tgt;

  assign op = ctl_op_e'(ins_op);

  npc_cond #(.XLEN(XLEN)) u_cond (
    .op        (op),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .cond_true (cond_true),
    .is_ctrl   (is_ctrl),
    .is_link   (is_link),
    .src       (src)
  );

  npc_target #(.XLEN(XLEN), .OFF_W(OFF_W)) u_target (
    .src       (src),
    .ins_pc    (ins_pc),
    .ins_imm   (ins_imm),
    .rs_val    (rs_val),
    .tgt       (tgt),
    .link_addr (link_addr)
  );

  // A transfer counts only outside the delay-slot cycle
  assign accept   = ins_valid & is_ctrl & ~pend_valid;
  assign taken    = accept & cond_true;
  assign link_we  = taken & is_link;
  assign link_reg = REG_W'(LINK_REG);

  npc_seq #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .redirect   (taken),
    .redir_tgt  (tgt),
    .fetch_pc   (fetch_pc),
    .pend_valid (pend_valid)
  );

  assert_link_needs_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> taken);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |-> (!taken && !link_we));

  assert_taken_is_ctrl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> is_ctrl);

endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;

  localparam logic [31:0] RST_ADDR = 32'h0040_0000;

  localparam logic [3:0] C_BEQ = 4'd1, C_BNE = 4'd2, C_BLEZ = 4'd3, C_BGTZ = 4'd4,
                         C_BLTZ = 4'd5, C_BGEZ = 4'd6, C_BLTZAL = 4'd7, C_BGEZAL = 4'd8,
                         C_J = 4'd9, C_JAL = 4'd10, C_JR = 4'd11;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] rs;
    logic [31:0] rt;
    logic [25:0] imm;
    logic [31:0] pc;
    logic        tk;
    logic        lk;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{C_BEQ,    32'd5,         32'd5,         26'h0000010, 32'h0040_0100, 1'b1, 1'b0},
    '{C_BEQ,    32'd5,         32'd6,         26'h0000010, 32'h0040_0100, 1'b0, 1'b0},
    '{C_BNE,    32'd5,         32'd6,         26'h000FFFC, 32'h0040_0200, 1'b1, 1'b0},
    '{C_BNE,    32'd7,         32'd7,         26'h000FFFC, 32'h0040_0200, 1'b0, 1'b0},
    '{C_BLEZ,   32'd0,         32'hDEAD_BEEF, 26'h0000008, 32'h0040_0300, 1'b1, 1'b0},
    '{C_BLEZ,   32'h8000_0000, 32'd0,         26'h0000008, 32'h0040_0300, 1'b1, 1'b0},
    '{C_BLEZ,   32'd1,         32'd1,         26'h0000008, 32'h0040_0300, 1'b0, 1'b0},
    '{C_BGTZ,   32'h8000_0000, 32'd5,         26'h0000020, 32'h0040_0400, 1'b0, 1'b0},
    '{C_BGTZ,   32'd1,         32'hDEAD_BEEF, 26'h0000020, 32'h0040_0400, 1'b1, 1'b0},
    '{C_BGTZ,   32'd0,         32'd9,         26'h0000020, 32'h0040_0400, 1'b0, 1'b0},
    '{C_BLTZ,   32'hFFFF_FFFF, 32'd0,         26'h000FF00, 32'h0040_0500, 1'b1, 1'b0},
    '{C_BLTZ,   32'd0,         32'hFFFF_FFFF, 26'h000FF00, 32'h0040_0500, 1'b0, 1'b0},
    '{C_BGEZ,   32'd0,         32'hFFFF_FFFF, 26'h0000004, 32'h0040_0600, 1'b1, 1'b0},
    '{C_BGEZ,   32'hFFFF_FFFF, 32'd0,         26'h0000004, 32'h0040_0600, 1'b0, 1'b0},
    '{C_BLTZAL, 32'hFFFF_FFFB, 32'd0,         26'h0000040, 32'h0040_0700, 1'b1, 1'b1},
    '{C_BLTZAL, 32'd3,         32'd0,         26'h0000040, 32'h0040_0700, 1'b0, 1'b0},
    '{C_BGEZAL, 32'd0,         32'd0,         26'h0000044, 32'h0040_0800, 1'b1, 1'b1},
    '{C_BGEZAL, 32'h8000_0000, 32'd0,         26'h0000044, 32'h0040_0800, 1'b0, 1'b0},
    '{C_J,      32'd0,         32'd0,         26'h0123456, 32'hA000_0FFC, 1'b1, 1'b0},
    '{C_J,      32'd0,         32'd0,         26'h3FFFFFF, 32'h3FFF_FFFC, 1'b1, 1'b0},
    '{C_JAL,    32'd0,         32'd0,         26'h0000040, 32'h0040_0900, 1'b1, 1'b1},
    '{C_JR,     32'h1234_5678, 32'd0,         26'h0000000, 32'h0040_0A00, 1'b1, 1'b0},
    '{4'd0,     32'd3,         32'd3,         26'h0000010, 32'h0040_0B00, 1'b0, 1'b0},
    '{4'd15,    32'd3,         32'd3,         26'h0000010, 32'h0040_0B00, 1'b0, 1'b0},
    '{C_BEQ,    32'd0,         32'd0,         26'h0007FFF, 32'h0040_0000, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic [3:0]  ins_op = 4'd0;
  logic [31:0] ins_pc = 32'd0;
  logic [25:0] ins_imm = 26'd0;
  logic [31:0] rs_val = 32'd0;
  logic [31:0] rt_val = 32'd0;
  logic [31:0] fetch_pc;
  logic        taken;
  logic        link_we;
  logic [4:0]  link_reg;
  logic [31:0] link_addr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  npc_unit u_npc_unit (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op),
    .ins_pc(ins_pc), .ins_imm(ins_imm), .rs_val(rs_val), .rt_val(rt_val),
    .fetch_pc(fetch_pc), .taken(taken), .link_we(link_we),
    .link_reg(link_reg), .link_addr(link_addr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string cond_tag(input logic [3:0] op);
    if (op == C_BEQ || op == C_BNE) return "R3";
    if (op >= C_BLEZ && op <= C_BGEZAL) return "R4";
    if (op == C_J || op == C_JAL) return "R6";
    if (op == C_JR) return "R7";
    return "R11";
  endfunction

  function automatic string tgt_tag(input logic [3:0] op);
    if (op >= C_BEQ && op <= C_BGEZAL) return "R5";
    if (op == C_J || op == C_JAL) return "R6";
    return "R7";
  endfunction

  function automatic logic [31:0] want_target(input vec_t v);
    int off;
    if (v.op == C_J || v.op == C_JAL)
      return ((v.pc + 32'd4) & 32'hF000_0000) | ({6'd0, v.imm} * 32'd4);
    if (v.op == C_JR) return v.rs;
    off = $signed(v.imm[15:0]);
    return v.pc + 32'(4 + off * 4);
  endfunction

  task automatic drive(input vec_t v, input logic valid);
    ins_valid = valid;
    ins_op    = v.op;
    ins_pc    = v.pc;
    ins_imm   = v.imm;
    rs_val    = v.rs;
    rt_val    = v.rt;
  endtask

  task automatic apply(input vec_t v);
    logic [31:0] base;
    logic [31:0] tgt;
    @(negedge clk);
    drive(v, 1'b1);
    #1;
    base = fetch_pc;
    tgt  = want_target(v);
    chk(taken == v.tk, cond_tag(v.op), "taken", {31'd0, taken}, {31'd0, v.tk});
    chk(link_we == v.lk, "R9", "link_we", {31'd0, link_we}, {31'd0, v.lk});
    if (v.lk) begin
      chk(link_addr == v.pc + 32'd8, "R9", "link_addr", link_addr, v.pc + 32'd8);
      chk(link_reg == 5'd31, "R9", "link_reg", {27'd0, link_reg}, 32'd31);
    end
    @(negedge clk);
    ins_valid = 1'b0;
    #1;
    chk(fetch_pc == base + 32'd4, "R8", "delay-slot fetch", fetch_pc, base + 32'd4);
    @(negedge clk);
    #1;
    if (v.tk)
      chk(fetch_pc == tgt, tgt_tag(v.op), "target fetch", fetch_pc, tgt);
    else
      chk(fetch_pc == base + 32'd8, "R2", "sequential fetch", fetch_pc, base + 32'd8);
  endtask

  initial begin : watchdog
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] p;
    vec_t v;
    repeat (3) @(negedge clk);
    #1;
    chk(fetch_pc == RST_ADDR, "R1", "reset fetch_pc", fetch_pc, RST_ADDR);
    chk(!taken && !link_we, "R1", "reset outputs", {30'd0, taken, link_we}, 32'd0);
    rst_n = 1'b1;
    #1;
    chk(fetch_pc == RST_ADDR, "R1", "fetch_pc after release", fetch_pc, RST_ADDR);

    // R2: plain sequential stepping from the reset address
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      #1;
      chk(fetch_pc == RST_ADDR + 32'(4 * k), "R2", "step", fetch_pc, RST_ADDR + 32'(4 * k));
    end

    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // R11: a would-be taken branch with ins_valid low
    @(negedge clk);
    drive(VEC[0], 1'b0);
    #1;
    p = fetch_pc;
    chk(!taken && !link_we, "R11", "invalid slot quiet", {30'd0, taken, link_we}, 32'd0);
    @(negedge clk);
    #1;
    @(negedge clk);
    #1;
    chk(fetch_pc == p + 32'd8, "R11", "invalid slot no redirect", fetch_pc, p + 32'd8);

    // R10: transfer presented in the delay-slot cycle is ignored
    v = VEC[20];
    @(negedge clk);
    drive(v, 1'b1);
    #1;
    p = fetch_pc;
    chk(taken && link_we, "R10", "first jump accepted", {30'd0, taken, link_we}, 32'd3);
    @(negedge clk);
    drive(VEC[0], 1'b1);
    v.op = C_JAL;
    #1;
    chk(!taken, "R10", "delay-slot branch taken", {31'd0, taken}, 32'd0);
    chk(!link_we, "R10", "delay-slot link", {31'd0, link_we}, 32'd0);
    chk(fetch_pc == p + 32'd4, "R8", "delay-slot fetch", fetch_pc, p + 32'd4);
    @(negedge clk);
    ins_valid = 1'b0;
    #1;
    chk(fetch_pc == want_target(VEC[20]), "R10", "first target kept",
        fetch_pc, want_target(VEC[20]));
    @(negedge clk);
    #1;
    chk(fetch_pc == want_target(VEC[20]) + 32'd4, "R2", "step after target",
        fetch_pc, want_target(VEC[20]) + 32'd4);

    // R1: reset in mid-run returns to the reset address
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(fetch_pc == RST_ADDR, "R1", "mid-run reset", fetch_pc, RST_ADDR);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule